// File: doc/BRIEF.md
# Camera Receiver Register File

This block is the software-visible control and status window of a serial camera-interface receiver. A simple 32-bit read/write bus reaches eight word registers: global control, PHY control, PHY status, format and lane configuration, frame resolution, interrupt mask, interrupt source and a read-only view of the configuration in use. The PHY, the packet parser and the pixel path are not part of it. They appear only as event inputs and as the configuration outputs that the block drives.

Configuration is held twice. Bus writes change a working copy. The outputs that steer the receiver follow a separate active copy, and that copy changes only when software issues an update command. Software can therefore rewrite several registers while a frame is in flight and switch the whole set at once. A software reset command runs for a fixed number of cycles and then returns both copies to their defaults. Receive errors and non-image-data events set sticky bits. Software clears these bits by writing ones. The interrupt line reports any set bit that is also enabled in the mask.

Top module: `cam_rx_regs`

## Requirements
- R1: After rst_n the registers read: control 0, PHY control 0, configuration 0x78 (data type 0x1E in bits 7:2, lane code 0 in bits 1:0), resolution 0x028001E0 (width 640 in bits 31:16, height 480 in bits 15:0), mask 0, source 0, active configuration 0x78. The outputs match these values.
- R2: Byte offsets are 0x00 control, 0x04 PHY control, 0x08 configuration, 0x0C PHY status, 0x10 mask, 0x14 source, 0x2C resolution, 0x38 active configuration. A read returns the working value at its offset, and unimplemented bits read 0. Mask and source implement only the bits of 0xF000F03F. Any access with address bits 1:0 not zero is ignored and reads 0.
- R3: Writes to configuration, PHY control, resolution and the control fields clock select (bit 8), 32-bit alignment (bit 20) and lane swap (bit 31) change no output. A control write with bit 16 set copies every working field to the active outputs one clock later. Offset 0x38 returns the active configuration.
- R4: Control bit 16 is a command. A read of control made later than one clock after the command returns bit 16 as 0.
- R5: The enable output follows control bit 0 at once. When enable is set, lane_en_o equals the active PHY lane field (bits 4:0, bit 0 is the clock lane) ANDed with the lowest (lane code + 2) bits. When enable is clear, lane_en_o is 0.
- R6: A resolution write stores a width or height field of 0 as 1. All other values from 1 to 65535 are stored unchanged.
- R7: An event input sets its source bit, and the bit stays set while the mask excludes it. Error inputs 5:0 map to bits 5:0, SOT inputs map to bits 15:12 and non-image-data inputs map to bits 31:28.
- R8: Writing to the source register clears exactly the bits written as 1. When an event arrives in the same cycle as the clear of its bit, the bit stays set.
- R9: irq_o is high exactly when source AND mask is nonzero.
- R10: Control bit 4 drives soft_rst_o high for RST_CYCLES clocks. In the cycle soft_rst_o falls, the working and active registers hold their R1 defaults. Mask and source are left unchanged.
- R11: Offset 0x0C reads phy_status_i. A write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per high cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| err_evt_i | input | 6 | Error event pulses |
| sot_err_i | input | NUM_LANES | Per-lane start-of-transmission error pulses |
| nid_evt_i | input | 4 | Non-image-data event pulses |
| phy_status_i | input | 32 | PHY status word |
| irq_o | output | 1 | Interrupt request |
| enable_o | output | 1 | Receiver enable |
| soft_rst_o | output | 1 | Software reset in progress |
| lane_en_o | output | NUM_LANES+1 | Lane enables, bit 0 is the clock lane |
| clk_ext_o | output | 1 | Active wrapper clock select |
| align32_o | output | 1 | Active 32-bit output alignment |
| swap_o | output | 1 | Active differential pair swap |
| settle_o | output | 5 | Active HS receive settle count |
| dtype_o | output | 6 | Active data-type code |
| lanes_o | output | 2 | Active lane code (data lanes minus one) |
| width_o | output | 16 | Active frame width |
| height_o | output | 16 | Active frame height |

## Verification
Two functions can act on the same source bit in one cycle: an event pulse setting it and a bus write clearing it. The bench drives an error pulse and a source write of that bit on the same falling edge, so both take effect on the same rising edge. It then reads the register and expects the bit still set. A second pair collides in the control word: the new field values and the update command arrive in a single write. The bench checks that the active outputs carry the new values one clock later.

// File: rtl/cam_rx_regs.sv
module cam_rx_regs #(
  parameter int ADDR_W     = 8,
  parameter int NUM_LANES  = 4,
  parameter int RST_CYCLES = 8,
  parameter int DEF_WIDTH  = 640,
  parameter int DEF_HEIGHT = 480,
  parameter logic [5:0] DEF_DTYPE = 6'h1E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [5:0]           err_evt_i,
  input  logic [NUM_LANES-1:0] sot_err_i,
  input  logic [3:0]           nid_evt_i,
  input  logic [31:0]          phy_status_i,
  output logic                 irq_o,
  output logic                 enable_o,
  output logic                 soft_rst_o,
  output logic [NUM_LANES:0]   lane_en_o,
  output logic                 clk_ext_o,
  output logic                 align32_o,
  output logic                 swap_o,
  output logic [4:0]           settle_o,
  output logic [5:0]           dtype_o,
  output logic [1:0]           lanes_o,
  output logic [15:0]          width_o,
  output logic [15:0]          height_o
);

  localparam int LANE_W = NUM_LANES + 1;
  localparam int AW     = ADDR_W - 2;
  localparam int CNT_W  = $clog2(RST_CYCLES + 1);
  localparam logic [31:0] IMPL = 32'hF000_F03F;
  localparam logic [AW-1:0] W_CTRL = AW'(0),  W_PHY = AW'(1),  W_CFG = AW'(2),
                            W_PST  = AW'(3),  W_MSK = AW'(4),  W_SRC = AW'(5),
                            W_RES  = AW'(11), W_SHD = AW'(14);
  localparam logic [15:0] DW = 16'(DEF_WIDTH);
  localparam logic [15:0] DH = 16'(DEF_HEIGHT);

  logic              en_q, ext_w, al_w, sw_w, ext_a, al_a, sw_a;
  logic [LANE_W-1:0] lane_w, lane_a;
  logic [4:0]        set_w, set_a;
  logic [5:0]        dt_w, dt_a;
  logic [1:0]        ln_w, ln_a;
  logic [15:0]       wd_w, wd_a, ht_w, ht_a;
  logic [31:0]       mask_q, src_q;
  logic              upd_pend;
  logic [CNT_W-1:0]  rst_cnt;

  wire           aligned = (bus_addr[1:0] == 2'b00);
  wire [AW-1:0]  word    = bus_addr[ADDR_W-1:2];
  wire           wr      = bus_sel & bus_wr & aligned;
  wire           wr_ctrl = wr && word == W_CTRL;
  wire           wr_phy  = wr && word == W_PHY;
  wire           wr_cfg  = wr && word == W_CFG;
  wire           wr_msk  = wr && word == W_MSK;
  wire           wr_src  = wr && word == W_SRC;
  wire           wr_res  = wr && word == W_RES;
  wire           rst_done = (rst_cnt == CNT_W'(1));

  wire [3:0]  sot4    = 4'(sot_err_i);
  wire [31:0] evt_vec = {nid_evt_i, 12'b0, sot4, 6'b0, err_evt_i};
  wire [LANE_W-1:0] lim = LANE_W'((1 << (32'(ln_a) + 2)) - 1);
  wire [15:0] wd_in = (bus_wdata[31:16] == 16'd0) ? 16'd1 : bus_wdata[31:16];
  wire [15:0] ht_in = (bus_wdata[15:0]  == 16'd0) ? 16'd1 : bus_wdata[15:0];

  assign enable_o   = en_q;
  assign soft_rst_o = (rst_cnt != '0);
  assign lane_en_o  = en_q ? (lane_a & lim) : '0;
  assign clk_ext_o  = ext_a;
  assign align32_o  = al_a;
  assign swap_o     = sw_a;
  assign settle_o   = set_a;
  assign dtype_o    = dt_a;
  assign lanes_o    = ln_a;
  assign width_o    = wd_a;
  assign height_o   = ht_a;
  assign irq_o      = |(src_q & mask_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && aligned) begin
      case (word)
        W_CTRL: begin
          bus_rdata[0]  = en_q;
          bus_rdata[4]  = soft_rst_o;
          bus_rdata[8]  = ext_w;
          bus_rdata[16] = upd_pend;
          bus_rdata[20] = al_w;
          bus_rdata[31] = sw_w;
        end
        W_PHY: begin
          bus_rdata[31:27]      = set_w;
          bus_rdata[LANE_W-1:0] = lane_w;
        end
        W_CFG:   bus_rdata[7:0] = {dt_w, ln_w};
        W_SHD:   bus_rdata[7:0] = {dt_a, ln_a};
        W_PST:   bus_rdata = phy_status_i;
        W_MSK:   bus_rdata = mask_q;
        W_SRC:   bus_rdata = src_q;
        W_RES:   bus_rdata = {wd_w, ht_w};
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ext_w <= 1'b0; al_w <= 1'b0; sw_w <= 1'b0;
      ext_a <= 1'b0; al_a <= 1'b0; sw_a <= 1'b0;
      lane_w <= '0; lane_a <= '0; set_w <= '0; set_a <= '0;
      dt_w <= DEF_DTYPE; dt_a <= DEF_DTYPE; ln_w <= '0; ln_a <= '0;
      wd_w <= DW; wd_a <= DW; ht_w <= DH; ht_a <= DH;
      upd_pend <= 1'b0;
      rst_cnt  <= '0;
    end else begin
      upd_pend <= wr_ctrl & bus_wdata[16];
      if (rst_cnt != '0)
        rst_cnt <= rst_cnt - CNT_W'(1);
      else if (wr_ctrl && bus_wdata[4])
        rst_cnt <= CNT_W'(RST_CYCLES);
      if (rst_done) begin
        en_q <= 1'b0; ext_w <= 1'b0; al_w <= 1'b0; sw_w <= 1'b0;
        ext_a <= 1'b0; al_a <= 1'b0; sw_a <= 1'b0;
        lane_w <= '0; lane_a <= '0; set_w <= '0; set_a <= '0;
        dt_w <= DEF_DTYPE; dt_a <= DEF_DTYPE; ln_w <= '0; ln_a <= '0;
        wd_w <= DW; wd_a <= DW; ht_w <= DH; ht_a <= DH;
      end else begin
        if (wr_ctrl) begin
          en_q  <= bus_wdata[0];
          ext_w <= bus_wdata[8];
          al_w  <= bus_wdata[20];
          sw_w  <= bus_wdata[31];
        end
        if (wr_phy) begin
          set_w  <= bus_wdata[31:27];
          lane_w <= bus_wdata[LANE_W-1:0];
        end
        if (wr_cfg) begin
          dt_w <= bus_wdata[7:2];
          ln_w <= bus_wdata[1:0];
        end
        if (wr_res) begin
          wd_w <= wd_in;
          ht_w <= ht_in;
        end
        if (upd_pend) begin
          ext_a <= ext_w; al_a <= al_w; sw_a <= sw_w;
          lane_a <= lane_w; set_a <= set_w;
          dt_a <= dt_w; ln_a <= ln_w;
          wd_a <= wd_w; ht_a <= ht_w;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      src_q  <= '0;
    end else begin
      if (wr_msk) mask_q <= bus_wdata & IMPL;
      src_q <= ((src_q & ~(wr_src ? bus_wdata : 32'd0)) | evt_vec) & IMPL;
    end
  end

  assert_hold_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_pend && !rst_done) |=> ($stable(dtype_o) && $stable(width_o) && $stable(settle_o) && $stable(lanes_o)))
    else $error("active configuration moved without update");

  assert_lanes_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_o |-> (lane_en_o == '0))
    else $error("lane enabled while block disabled");

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_src |=> ((src_q & $past(src_q)) == $past(src_q)))
    else $error("source bit lost without clear");

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_src |=> ((src_q & $past(bus_wdata) & ~$past(evt_vec)) == 32'd0))
    else $error("cleared source bit survived");

  assert_rst_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst_o) |-> (width_o == DW && height_o == DH && dtype_o == DEF_DTYPE && !enable_o))
    else $error("defaults not restored after software reset");

endmodule

// File: tb/test_cam_rx_regs.sv
`timescale 1ns/1ps
module test_cam_rx_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [5:0]  err_evt_i = '0;
  logic [3:0]  sot_err_i = '0;
  logic [3:0]  nid_evt_i = '0;
  logic [31:0] phy_status_i = 32'hA5A5_5A5A;
  logic        irq_o, enable_o, soft_rst_o, clk_ext_o, align32_o, swap_o;
  logic [4:0]  lane_en_o, settle_o;
  logic [5:0]  dtype_o;
  logic [1:0]  lanes_o;
  logic [15:0] width_o, height_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] r;

  localparam logic [31:0] IMPL = 32'hF000_F03F;

  always #2.5 clk = ~clk;

  cam_rx_regs i_cam_rx_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic ev(input logic [31:0] v);
    @(negedge clk); err_evt_i = v[5:0]; sot_err_i = v[15:12]; nid_evt_i = v[31:28];
    @(negedge clk); err_evt_i = '0; sot_err_i = '0; nid_evt_i = '0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, r); chk("R1 ctrl", r, 0);
    rd(8'h04, r); chk("R1 phy", r, 0);
    rd(8'h08, r); chk("R1 cfg", r, 32'h78);
    rd(8'h2C, r); chk("R1 res", r, 32'h0280_01E0);
    rd(8'h10, r); chk("R1 mask", r, 0);
    rd(8'h14, r); chk("R1 src", r, 0);
    rd(8'h38, r); chk("R1 shadow", r, 32'h78);
    chk("R1 outputs", {dtype_o, lanes_o, width_o, height_o, 8'(lane_en_o)},
        {6'h1E, 2'd0, 16'd640, 16'd480, 8'd0});
    chk("R1 irq/enable", {irq_o, enable_o, soft_rst_o}, 0);

    // R11 status read-only
    rd(8'h0C, r); chk("R11 status read", r, 32'hA5A5_5A5A);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, r); chk("R11 status after write", r, 32'hA5A5_5A5A);
    rd(8'h08, r); chk("R11 cfg untouched", r, 32'h78);

    // R2 reserved bits and misaligned access
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, r); chk("R2 mask impl bits", r, IMPL);
    wr(8'h10, 0);
    wr(8'h09, 32'hFF);
    rd(8'h08, r); chk("R2 misaligned write ignored", r, 32'h78);
    rd(8'h0A, r); chk("R2 misaligned read zero", r, 0);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, r); chk("R2 cfg reserved", r, 32'hFF);

    // R3 working vs active
    wr(8'h08, (32'h2B << 2) | 2);
    wr(8'h04, (32'd7 << 27) | 32'h1F);
    wr(8'h2C, 32'h0100_0080);
    wr(8'h00, 32'h8010_0100);
    rd(8'h08, r); chk("R3 cfg working", r, 32'hAE);
    rd(8'h38, r); chk("R3 shadow before update", r, 32'h78);
    chk("R3 outputs before update", {dtype_o, lanes_o, settle_o, width_o, clk_ext_o, align32_o, swap_o},
        {6'h1E, 2'd0, 5'd0, 16'd640, 3'b000});
    // fields and update command in one write
    wr(8'h00, 32'h8011_0100);
    @(negedge clk);
    chk("R3 outputs after update", {dtype_o, lanes_o, settle_o, width_o, height_o, clk_ext_o, align32_o, swap_o},
        {6'h2B, 2'd2, 5'd7, 16'h0100, 16'h0080, 3'b111});
    rd(8'h38, r); chk("R3 shadow after update", r, 32'hAE);
    rd(8'h00, r); chk("R4 update bit self clears", r, 32'h8010_0100);
    chk("R5 disabled lanes off", 32'(lane_en_o), 0);

    // R5 lane enable sweep
    for (int l = 0; l < 4; l++) begin
      for (int f = 0; f < 32; f++) begin
        wr(8'h08, 32'(l));
        wr(8'h04, 32'(f));
        wr(8'h00, 32'h0001_0001);
        @(negedge clk);
        chk($sformatf("R5 lanes l=%0d f=%0d", l, f), 32'(lane_en_o), 32'(f & ((1 << (l + 2)) - 1)));
      end
    end
    wr(8'h00, 0);
    chk("R5 lanes off after disable", 32'(lane_en_o), 0);

    // R6 resolution clamp sweep
    foreach (r[i]) begin end
    for (int wi = 0; wi < 4; wi++) begin
      for (int hi = 0; hi < 3; hi++) begin
        logic [15:0] wv, hv;
        wv = (wi == 0) ? 16'd0 : (wi == 1) ? 16'd1 : (wi == 2) ? 16'hFFFF : 16'h1234;
        hv = (hi == 0) ? 16'd0 : (hi == 1) ? 16'd1 : 16'hFFFF;
        wr(8'h2C, {wv, hv});
        rd(8'h2C, r);
        chk("R6 resolution clamp", r, {(wv == 0) ? 16'd1 : wv, (hv == 0) ? 16'd1 : hv});
      end
    end

    // R7 R9 per-bit sticky and mask sweep
    for (int b = 0; b < 32; b++) begin
      if (IMPL[b]) begin
        ev(32'd1 << b);
        rd(8'h14, r); chk($sformatf("R7 sticky bit %0d", b), r, 32'd1 << b);
        chk("R9 masked no irq", 32'(irq_o), 0);
        wr(8'h10, 32'd1 << b);
        chk("R9 irq on", 32'(irq_o), 1);
        wr(8'h10, ~(32'd1 << b));
        chk("R9 other mask no irq", 32'(irq_o), 0);
        wr(8'h14, 32'd1 << b);
        rd(8'h14, r); chk("R8 w1c single", r, 0);
        wr(8'h10, 0);
      end
    end

    // R8 partial clear and same-cycle collision
    ev(32'h4000_1005);
    wr(8'h14, 32'h4000_0004);
    rd(8'h14, r); chk("R8 partial clear", r, 32'h0000_1001);
    wr(8'h14, 32'hFFFF_FFFF);
    ev(32'h8);
    @(negedge clk);
    err_evt_i = 6'h08; bus_sel = 1; bus_wr = 1; bus_addr = 8'h14; bus_wdata = 32'h8;
    @(negedge clk);
    err_evt_i = 0; bus_sel = 0; bus_wr = 0;
    rd(8'h14, r); chk("R8 event wins over clear", r, 32'h8);
    wr(8'h14, 32'h8);
    rd(8'h14, r); chk("R8 clear after collision", r, 0);

    // R10 software reset
    wr(8'h10, 32'h3F);
    ev(32'h2);
    wr(8'h08, 32'hAF);
    wr(8'h2C, 32'h0010_0020);
    wr(8'h00, 32'h0011_0101);
    @(negedge clk);
    chk("R10 pre-reset width", 32'(width_o), 32'h10);
    wr(8'h00, 32'h10);
    begin
      int n = 0;
      while (soft_rst_o && n < 100) begin n++; @(negedge clk); end
      chk("R10 reset pulse length", n, 8);
    end
    chk("R10 outputs default", {dtype_o, lanes_o, width_o, height_o, 8'(enable_o)},
        {6'h1E, 2'd0, 16'd640, 16'd480, 8'd0});
    rd(8'h08, r); chk("R10 cfg default", r, 32'h78);
    rd(8'h2C, r); chk("R10 res default", r, 32'h0280_01E0);
    rd(8'h10, r); chk("R10 mask kept", r, 32'h3F);
    rd(8'h14, r); chk("R10 src kept", r, 32'h2);
    chk("R9 irq after reset", 32'(irq_o), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule